// File: doc/BRIEF.md
# Iterative SOD Accumulation Buffers

This block holds the sum-of-differences (SOD) results that a line search engine produces for an 8×8 region search. A region is searched as eight lines, and each line has eight candidate positions. For every candidate the engine delivers sixteen 4×4 sub-block SODs. The region may be searched several times (φ iterations). Each time a line comes round again, its new SODs are added element by element onto the values already stored for that line.

A region begins with a one-cycle `start` pulse that carries the iteration count. That cycle clears every stored sum. The block then takes one line of SODs per `in_valid` beat. It visits lines 0 to 7 in order, once per iteration. After the last beat of the last iteration it streams out the final sums, one line per cycle, for eight cycles. The output is a combinational view of the stored line, and `out_line` identifies the line. While a region is being accumulated or streamed out, `busy` is high and a new `start` has no effect.

Top module: `sodacc_buffers`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0 and `out_sods` is all zero.
- R2: When `busy` is low, a `start` pulse with a nonzero `iters` is accepted. `busy` then goes high in the next cycle and stays high up to and including the cycle that shows the last output line.
- R3: The cycle that accepts a `start` clears every stored sum, so nothing from a previous region reaches the new region's outputs.
- R4: Each `in_valid` beat during accumulation adds `in_sods` element-wise to one stored line. Beat k of a region goes to line k mod 8, so lines 0 to 7 are visited in order in every iteration.
- R5: Element e = 16·candidate + sub-block sits at bits [e·5 +: 5] of `in_sods` and at bits [e·8 +: 8] of `out_sods`.
- R6: If `start` is sampled in cycle 0 and beats arrive without a gap, line r is presented with `out_valid` high in cycle 8φ+1+r. `out_valid` stays high for exactly eight cycles, and `out_line` counts 0 to 7 during them.
- R7: A cycle with `in_valid` low during accumulation adds nothing and does not advance the line. Each such cycle delays the output by one cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The running region keeps its iteration count and its sums.
- R9: A `start` with `iters` equal to 0 is ignored, and `busy` stays low.
- R10: `in_valid` beats that arrive while the block is idle or streaming out change no stored sum.
- R11: With φ = 15 and every input element at 16, every output element reads 240, with no wrap.
- R12: `out_sods` is all zero in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a region search and clears the stored sums |
| iters | input | ITER_W (4) | Iteration count φ, sampled with `start` |
| in_valid | input | 1 | One line of SODs is present on `in_sods` |
| in_sods | input | 128·IN_W (640) | 128 sub-block SODs for one line, element e at [e·IN_W +: IN_W] |
| busy | output | 1 | A region is being accumulated or streamed out |
| out_valid | output | 1 | `out_sods` carries a final line |
| out_line | output | 3 | Index of the line on `out_sods` |
| out_sods | output | 128·ACC_W (1024) | Final accumulated SODs for one line, element e at [e·ACC_W +: ACC_W] |

## Verification
The hardest case to reach from the ports is a `start` or an `in_valid` that arrives while a multi-iteration region is already running. Such a pulse must not re-seed the iteration count, clear the sums or leak into a line that has finished. The stimulus reaches this case by pulsing `start` with a different count in the middle of accumulation, and again across the whole output stream. It also holds `in_valid` high with nonzero data while the lines stream out, and it inserts idle beats inside accumulation. A behavioural model, compared on every clock, together with a cycle count from the start pulse to the first output line, then shows whether the pulses were truly ignored.

// File: rtl/sodacc_pkg.sv
package sodacc_pkg;

   // Sequencing state of one region search
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACC  = 2'd1,
      PH_OUT  = 2'd2
   } phase_e;

endpackage

// File: rtl/sodacc_ctrl.sv
module sodacc_ctrl
   import sodacc_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int ITER_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ITER_W-1:0]          iters,
   input  logic                       in_valid,
   output logic                       busy,
   output logic                       clear,
   output logic [LINES-1:0]           acc_en,
   output logic                       out_valid,
   output logic [$clog2(LINES)-1:0]   out_line
);

   localparam int LINE_W = $clog2(LINES);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   phase_e              phase_q;
   logic [LINE_W-1:0]   line_q;
   logic [ITER_W-1:0]   iter_q;
   logic [ITER_W-1:0]   iters_q;

   logic accept;
   logic line_last;
   logic iter_last;

   // R2 R8 R9: a start is taken only when idle and with a nonzero count
   assign accept    = (phase_q == PH_IDLE) && start && (iters != '0);
   assign line_last = (line_q == LAST_LINE);
   assign iter_last = (iter_q == iters_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         line_q  <= '0;
         iter_q  <= '0;
         iters_q <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  phase_q <= PH_ACC;
                  line_q  <= '0;
                  iter_q  <= ITER_W'(1);
                  iters_q <= iters;
               end
            end
            PH_ACC: begin
               // R7: the line pointer only moves on a valid beat
               if (in_valid) begin
                  if (line_last) begin
                     line_q <= '0;
                     if (iter_last) begin
                        phase_q <= PH_OUT;
                     end else begin
                        iter_q <= iter_q + ITER_W'(1);
                     end
                  end else begin
                     line_q <= line_q + LINE_W'(1);
                  end
               end
            end
            PH_OUT: begin
               if (line_last) begin
                  phase_q <= PH_IDLE;
                  line_q  <= '0;
               end else begin
                  line_q <= line_q + LINE_W'(1);
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               line_q  <= '0;
            end
         endcase
      end
   end

   assign clear     = accept;
   assign busy      = (phase_q != PH_IDLE);
   assign out_valid = (phase_q == PH_OUT);
   assign out_line  = line_q;

   // R4 R10: one line write enable per bank, live only during accumulation
   generate
      for (genvar l = 0; l < LINES; l++) begin : g_en
         assign acc_en[l] = (phase_q == PH_ACC) && in_valid
                            && (line_q == LINE_W'(l));
      end
   endgenerate

endmodule

// File: rtl/sodacc_line.sv
module sodacc_line #(
   parameter int ELEMS = 128,
   parameter int IN_W  = 5,
   parameter int ACC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    add_en,
   input  logic [ELEMS*IN_W-1:0]   add_vec,
   output logic [ELEMS*ACC_W-1:0]  sum_vec
);

   // One accumulator per candidate/sub-block pair (R4 R5)
   generate
      for (genvar e = 0; e < ELEMS; e++) begin : g_elem
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] addend;

         assign addend = ACC_W'(add_vec[e*IN_W +: IN_W]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (clear) begin
               acc_q <= '0;              // R3
            end else if (add_en) begin
               acc_q <= acc_q + addend;
            end
         end

         assign sum_vec[e*ACC_W +: ACC_W] = acc_q;
      end
   endgenerate

endmodule

// File: rtl/sodacc_out_sel.sv
module sodacc_out_sel #(
   parameter int LINES = 8,
   parameter int BUS_W = 1024
) (
   input  logic [LINES-1:0][BUS_W-1:0]  lines,
   input  logic [$clog2(LINES)-1:0]     sel,
   input  logic                         valid,
   output logic [BUS_W-1:0]             data
);

   // R12: the bus is held at zero whenever no line is being presented
   always_comb begin
      data = '0;
      if (valid) begin
         data = lines[sel];
      end
   end

endmodule

// File: rtl/sodacc_buffers.sv
module sodacc_buffers #(
   parameter int LINES    = 8,
   parameter int CANDS    = 8,
   parameter int SUBS     = 16,
   parameter int BLK_PIX  = 16,
   parameter int IN_W     = 5,
   parameter int ACC_W    = 8,
   parameter int ITER_W   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [ITER_W-1:0]                 iters,
   input  logic                              in_valid,
   input  logic [CANDS*SUBS*IN_W-1:0]        in_sods,
   output logic                              busy,
   output logic                              out_valid,
   output logic [$clog2(LINES)-1:0]          out_line,
   output logic [CANDS*SUBS*ACC_W-1:0]       out_sods
);

   localparam int ELEMS    = CANDS * SUBS;
   localparam int LINE_W   = $clog2(LINES);
   localparam int OUT_BUS  = ELEMS * ACC_W;
   localparam int MAX_ITER = (1 << ITER_W) - 1;

   // Elaboration-time parameter checks
   generate
      if (LINES < 2) begin : g_bad_lines
         $error("sodacc_buffers: LINES must be at least 2");
      end
      if (ACC_W < IN_W) begin : g_bad_widths
         $error("sodacc_buffers: ACC_W must not be narrower than IN_W");
      end
      if (BLK_PIX > (1 << IN_W) - 1) begin : g_bad_in_w
         $error("sodacc_buffers: IN_W too narrow for one sub-block SOD");
      end
      if (MAX_ITER * BLK_PIX > (1 << ACC_W) - 1) begin : g_bad_acc_w
         $error("sodacc_buffers: ACC_W can overflow at the largest count (R11)");
      end
   endgenerate

   logic                              clear;
   logic [LINES-1:0]                  acc_en;
   logic [LINES-1:0][OUT_BUS-1:0]     line_sums;

   sodacc_ctrl #(
      .LINES  (LINES),
      .ITER_W (ITER_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .iters     (iters),
      .in_valid  (in_valid),
      .busy      (busy),
      .clear     (clear),
      .acc_en    (acc_en),
      .out_valid (out_valid),
      .out_line  (out_line)
   );

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_line
         sodacc_line #(
            .ELEMS (ELEMS),
            .IN_W  (IN_W),
            .ACC_W (ACC_W)
         ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .add_en  (acc_en[l]),
            .add_vec (in_sods),
            .sum_vec (line_sums[l])
         );
      end
   endgenerate

   sodacc_out_sel #(
      .LINES (LINES),
      .BUS_W (OUT_BUS)
   ) u_out (
      .lines (line_sums),
      .sel   (out_line),
      .valid (out_valid),
      .data  (out_sods)
   );

endmodule

// File: rtl/sodacc_checker.sv
module sodacc_checker #(
   parameter int LINES  = 8,
   parameter int ITER_W = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [ITER_W-1:0]          iters,
   input logic                       busy,
   input logic                       out_valid,
   input logic [$clog2(LINES)-1:0]   out_line
);

   localparam int LINE_W = $clog2(LINES);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (iters != '0)) |=> (busy && !out_valid));

   p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (iters == '0)) |=> !busy);

   p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(out_valid && (out_line == LAST_LINE))) |=> busy);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_line == LAST_LINE)) |=> !busy);

   p_first_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_line == '0));

   p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_line != LAST_LINE))
      |=> (out_valid && (out_line == $past(out_line) + LINE_W'(1))));

endmodule

bind sodacc_buffers sodacc_checker #(
   .LINES  (LINES),
   .ITER_W (ITER_W)
) u_sodacc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .iters     (iters),
   .busy      (busy),
   .out_valid (out_valid),
   .out_line  (out_line)
);

// File: tb/sodacc_buffers_tb.sv
module sodacc_buffers_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LINES  = 8;
   localparam int ELEMS  = 128;
   localparam int IN_W   = 5;
   localparam int ACC_W  = 8;
   localparam int ITER_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ITER_W-1:0] iters = '0;
   logic in_valid = 1'b0;
   logic [ELEMS*IN_W-1:0] in_sods = '0;
   logic busy;
   logic out_valid;
   logic [2:0] out_line;
   logic [ELEMS*ACC_W-1:0] out_sods;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   bit cmp_en = 1'b0;

   logic [ELEMS*ACC_W-1:0] got_q [LINES];

   sodacc_buffers dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .iters     (iters),
      .in_valid  (in_valid),
      .in_sods   (in_sods),
      .busy      (busy),
      .out_valid (out_valid),
      .out_line  (out_line),
      .out_sods  (out_sods)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_mem [LINES][ELEMS];
   int m_phase = 0;   // 0 idle, 1 accumulate, 2 output
   int m_line = 0;
   int m_iter = 0;
   int m_iters = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_line = 0; m_iter = 0; m_iters = 0;
         for (int l = 0; l < LINES; l++)
            for (int e = 0; e < ELEMS; e++) m_mem[l][e] = 0;
      end else begin
         case (m_phase)
            0: if (start && iters != 0) begin
                  for (int l = 0; l < LINES; l++)
                     for (int e = 0; e < ELEMS; e++) m_mem[l][e] = 0;
                  m_iters = int'(iters); m_iter = 1; m_line = 0; m_phase = 1;
               end
            1: if (in_valid) begin
                  for (int e = 0; e < ELEMS; e++)
                     m_mem[m_line][e] += int'(in_sods[e*IN_W +: IN_W]);
                  if (m_line == LINES - 1) begin
                     m_line = 0;
                     if (m_iter == m_iters) m_phase = 2;
                     else m_iter++;
                  end else m_line++;
               end
            default: begin
               if (m_line == LINES - 1) begin m_phase = 0; m_line = 0; end
               else m_line++;
            end
         endcase
      end
   end

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         logic [ELEMS*ACC_W-1:0] ev;
         int bad_e;
         ev = '0;
         if (m_phase == 2)
            for (int e = 0; e < ELEMS; e++) ev[e*ACC_W +: ACC_W] = ACC_W'(m_mem[m_line][e]);
         check("R2", "busy", longint'(busy), longint'(m_phase != 0));
         check("R6", "out_valid", longint'(out_valid), longint'(m_phase == 2));
         if (m_phase == 2) check("R6", "out_line", longint'(out_line), longint'(m_line));
         n_checks++;
         if (out_sods !== ev) begin
            bad_e = 0;
            for (int e = ELEMS - 1; e >= 0; e--)
               if (out_sods[e*ACC_W +: ACC_W] !== ev[e*ACC_W +: ACC_W]) bad_e = e;
            n_fail++;
            $display("FAIL %s out_sods elem %0d: actual %0d expected %0d",
                     (m_phase == 2) ? "R4" : "R12", bad_e,
                     out_sods[bad_e*ACC_W +: ACC_W], ev[bad_e*ACC_W +: ACC_W]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [ELEMS*IN_W-1:0] make_vec(input int pat, input int beat);
      logic [ELEMS*IN_W-1:0] v;
      v = '0;
      for (int e = 0; e < ELEMS; e++) begin
         case (pat)
            0: v[e*IN_W +: IN_W] = IN_W'($urandom_range(16, 0));
            1: v[e*IN_W +: IN_W] = IN_W'(16);
            3: if (beat % 8 == 3 && e == 2*16 + 5) v[e*IN_W +: IN_W] = IN_W'(7);
            default: v[e*IN_W +: IN_W] = '0;
         endcase
      end
      return v;
   endfunction

   task automatic run_region(input int phi, input int pat, input int gap_every,
                             input bit poke, output int rel_first);
      int t0;
      int seen;
      int waited;
      @(negedge clk);
      start = 1'b1; iters = ITER_W'(phi); t0 = cyc;
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < 8*phi; b++) begin
         if (gap_every > 0 && b % gap_every == gap_every - 1) begin
            in_valid = 1'b0; in_sods = make_vec(0, 0); start = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1; in_sods = make_vec(pat, b);
         if (poke && b == 5) begin start = 1'b1; iters = ITER_W'(1); end
         else start = 1'b0;
         @(negedge clk);
      end
      // during output: optionally keep in_valid and start pulsing (R8 R10)
      in_valid = poke; in_sods = poke ? make_vec(1, 0) : '0;
      start = poke; iters = ITER_W'(2);
      rel_first = -1; seen = 0; waited = 0;
      while (seen < LINES && waited < 400) begin
         if (out_valid) begin
            if (rel_first < 0) rel_first = cyc - t0;
            got_q[out_line] = out_sods;
            seen++;
         end
         @(negedge clk);
         waited++;
      end
      start = 1'b0; in_valid = 1'b0; in_sods = '0;
      check("R6", "lines presented", seen, LINES);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      int rel;
      int bad;
      int total;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", busy, 0);
      check("R1", "out_valid after reset", out_valid, 0);
      check("R1", "out_sods after reset", longint'(out_sods != '0), 0);
      cmp_en = 1'b1;

      // R10: beats while idle do nothing visible
      in_valid = 1'b1; in_sods = make_vec(1, 0);
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      check("R10", "busy after idle beats", busy, 0);
      check("R12", "out_sods while idle", longint'(out_sods != '0), 0);

      // R9: zero count start is dropped
      start = 1'b1; iters = '0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R9", "busy after zero-count start", busy, 0);

      // R6: single iteration, continuous
      run_region(1, 0, 0, 1'b0, rel);
      check("R6", "first output cycle phi=1", rel, 9);

      // R7 R8 R10: three iterations, gaps, stray starts and beats
      run_region(3, 0, 5, 1'b1, rel);
      check("R7", "first output cycle with 4 gaps", rel, 8*3 + 1 + 4);
      check("R8", "stray start did not shorten region", longint'(rel != 9), 1);

      // R11: largest count, largest inputs
      run_region(15, 1, 0, 1'b0, rel);
      check("R6", "first output cycle phi=15", rel, 121);
      bad = 0;
      for (int l = 0; l < LINES; l++)
         for (int e = 0; e < ELEMS; e++)
            if (got_q[l][e*ACC_W +: ACC_W] != 8'd240) bad++;
      check("R11", "elements not equal to 240", bad, 0);

      // R3 R5: single marked element after a full region
      run_region(1, 3, 0, 1'b0, rel);
      check("R5", "line 3 cand 2 sub 5", got_q[3][(2*16+5)*ACC_W +: ACC_W], 7);
      check("R3", "line 0 elem 0 after clear", got_q[0][0 +: ACC_W], 0);
      total = 0;
      for (int l = 0; l < LINES; l++)
         for (int e = 0; e < ELEMS; e++) total += int'(got_q[l][e*ACC_W +: ACC_W]);
      check("R3", "sum over region after clear", total, 7);

      // R4 R6: two iterations, continuous
      run_region(2, 0, 0, 1'b0, rel);
      check("R6", "first output cycle phi=2", rel, 17);

      repeat (4) @(negedge clk);
      check("R2", "idle at end", busy, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule